// File: doc/BRIEF.md
# Packed Quotient/Remainder Sequential Divider

This unit divides a double-width dividend by a single-width divisor over a fixed number of clock cycles. It has two operand sizes. The narrow size divides a 16-bit dividend by an 8-bit divisor. The wide size divides a 32-bit dividend by a 16-bit divisor. Each size can run as an unsigned or a two's-complement signed operation. The quotient and the remainder come back packed into one register-wide word, so the caller writes the result back over the dividend register in one step.

The caller raises `start_i` for one cycle with the size, the signedness and the operands. Some clock cycles later, `done_o` pulses for one cycle with the packed result. The number of cycles depends only on the size and the signedness. `flag_we_o` pulses at the same time as `done_o`, and only two condition flags come with it: a negative flag and a zero flag. Internally the unit works on magnitudes with a restoring shift-subtract loop that produces one quotient bit per cycle. Idle cycles pad the loop up to the fixed count. The unit detects a zero divisor and a quotient that does not fit. It reports neither as an exception: in both cases the result word is the dividend, returned unchanged.

Top module: `packed_divider`

## Requirements
- R1: Narrow unsigned form: `result_o[15:8]` holds the remainder of `dividend_i[15:0] / divisor_i[7:0]` and `result_o[7:0]` holds the quotient. In every narrow-form result, `result_o[31:16]` equals `dividend_i[31:16]`.
- R2: Wide unsigned form: `result_o[31:16]` holds the remainder of `dividend_i / divisor_i` and `result_o[15:0]` holds the quotient.
- R3: Signed forms read the dividend (narrow: bits 15:0; wide: bits 31:0) and the divisor (narrow: bits 7:0; wide: bits 15:0) as two's complement. The quotient truncates toward zero, and a nonzero remainder carries the sign of the dividend. The packing is the same as in R1 and R2.
- R4: After the rising clock edge that accepts `start_i`, `done_o` goes high at exactly edge 14 (narrow unsigned), 22 (wide unsigned), 16 (narrow signed) or 24 (wide signed), and it stays high for one cycle only.
- R5: `flag_we_o` is high in exactly the cycles in which `done_o` is high. `flag_n_o` and `flag_z_o` take new values only in those cycles.
- R6: `flag_z_o` is 1 exactly when the divisor operand of the selected size is zero. In that case the result word equals `dividend_i`, unchanged.
- R7: Unsigned: `flag_n_o` is the most significant bit of the divisor operand (bit 7 or bit 15). Signed: `flag_n_o` is the sign bit of the dividend operand (bit 15 or bit 31) XOR the sign bit of the divisor operand.
- R8: If the quotient does not fit the result field, the result word equals `dividend_i` and the flags still follow R6 and R7. Not fitting means, for unsigned, a quotient of 2^N or more. For signed, it means a quotient outside the range from -2^(N-1) to 2^(N-1)-1. N is 8 for the narrow size and 16 for the wide size.
- R9: The unit ignores `start_i` while an operation is in progress. The running operation finishes with its own operands, and the ignored request produces no later completion.
- R10: While reset is applied and after it: `result_o`, `flag_n_o`, `flag_z_o`, `flag_we_o` and `done_o` are all 0.
- R11: Between completions, `result_o`, `flag_n_o` and `flag_z_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a divide; accepted only when idle |
| word_i | input | 1 | 1 = wide form (32/16), 0 = narrow form (16/8) |
| signed_i | input | 1 | 1 = two's-complement operands |
| dividend_i | input | 32 | Dividend register value |
| divisor_i | input | 16 | Divisor register value (narrow form uses bits 7:0) |
| result_o | output | 32 | Packed remainder and quotient, or the unchanged dividend |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero-divisor flag |
| flag_we_o | output | 1 | Flag update strobe |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a signed quotient that sits exactly on the edge of its field. The case of -2^(N-1) is legal. The case of +2^(N-1) is an overflow, and it must return the dividend unchanged. Random operands almost never land on either edge. The bench therefore sweeps every narrow divisor against dividends built as divisor times a chosen quotient plus a small remainder, and adds fixed boundary pairs for both sizes. A second hard case is a request that arrives in the middle of a run. The bench raises `start_i` with different operands partway through an operation. It then checks that the first result is intact and that no second completion appears.

// File: rtl/packed_divider_pkg.sv
package packed_divider_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    // Operation configuration captured at acceptance
    typedef struct packed {
        logic word;
        logic sgn;
    } div_cfg_t;

    // Side information produced while the operands are conditioned
    typedef struct packed {
        logic q_neg;     // quotient must be negated at the end
        logic r_neg;     // remainder must be negated at the end
        logic ovf;       // high half of magnitude >= divisor magnitude
        logic zero;      // divisor operand is zero
        logic n;         // negative flag value
    } div_info_t;

    // Number of shift-subtract steps for a given narrow width
    function automatic int unsigned step_count(int unsigned bw, logic word);
        return word ? 2 * bw : bw;
    endfunction

    // Fixed total latency in clock edges after acceptance
    function automatic int unsigned op_latency(int unsigned bw, logic word, logic sgn);
        return step_count(bw, word) + 6 + (sgn ? 2 : 0);
    endfunction

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import packed_divider_pkg::*;
#(
    parameter int unsigned BW = 8
) (
    input  logic              word,
    input  logic              sgn,
    input  logic [4*BW-1:0]   dvd,
    input  logic [2*BW-1:0]   dvs,
    output logic [2*BW-1:0]   rem_init,
    output logic [2*BW-1:0]   q_init,
    output logic [2*BW-1:0]   dvs_mag,
    output div_info_t         info
);
    localparam int unsigned WW = 2 * BW;
    localparam int unsigned DW = 2 * WW;

    logic [DW-1:0] dd_ext;
    logic [DW-1:0] dd_mag;
    logic [WW-1:0] dv_ext;
    logic          d_neg;
    logic          v_neg;

    always_comb begin
        // Extend the selected operand size to the wide datapath
        if (word) begin
            dd_ext = dvd;
            dv_ext = dvs;
        end else begin
            dd_ext = {{WW{sgn & dvd[WW-1]}}, dvd[WW-1:0]};
            dv_ext = {{BW{sgn & dvs[BW-1]}}, dvs[BW-1:0]};
        end

        d_neg   = sgn & dd_ext[DW-1];
        v_neg   = sgn & dv_ext[WW-1];
        dd_mag  = d_neg ? (~dd_ext + 1'b1) : dd_ext;
        dvs_mag = v_neg ? (~dv_ext + 1'b1) : dv_ext;

        // Narrow form parks its low dividend byte at the top of the
        // quotient shifter so the same loop feeds it in first.
        if (word) begin
            rem_init = dd_mag[DW-1:WW];
            q_init   = dd_mag[WW-1:0];
        end else begin
            rem_init = {{BW{1'b0}}, dd_mag[WW-1:BW]};
            q_init   = {dd_mag[BW-1:0], {BW{1'b0}}};
        end

        info.q_neg = d_neg ^ v_neg;
        info.r_neg = d_neg;
        info.ovf   = (rem_init >= dvs_mag);
        info.zero  = (dv_ext == '0);
        info.n     = sgn ? (d_neg ^ v_neg) : (word ? dvs[WW-1] : dvs[BW-1]);
    end

endmodule

// File: rtl/div_step_core.sv
module div_step_core #(
    parameter int unsigned WW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [WW-1:0] rem_init,
    input  logic [WW-1:0] q_init,
    input  logic [WW-1:0] dvs,
    output logic [WW-1:0] rem_o,
    output logic [WW-1:0] q_o
);
    logic [WW-1:0] rem_r;
    logic [WW-1:0] q_r;
    logic [WW:0]   shifted;
    logic [WW-1:0] diff;
    logic          ge;

    always_comb begin
        shifted = {rem_r, q_r[WW-1]};
        ge      = (shifted >= {1'b0, dvs});
        diff    = shifted[WW-1:0] - dvs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_r <= '0;
            q_r   <= '0;
        end else if (load) begin
            rem_r <= rem_init;
            q_r   <= q_init;
        end else if (step) begin
            rem_r <= ge ? diff : shifted[WW-1:0];
            q_r   <= {q_r[WW-2:0], ge};
        end
    end

    assign rem_o = rem_r;
    assign q_o   = q_r;

    // A partial remainder below the divisor stays below it after a step
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        (step && !load && (rem_r < dvs)) |=> (rem_r < $past(dvs)));  // R2

endmodule

// File: rtl/div_result_pack.sv
module div_result_pack #(
    parameter int unsigned BW = 8
) (
    input  logic              word,
    input  logic              sgn,
    input  logic              q_neg,
    input  logic              r_neg,
    input  logic              ovf_pre,
    input  logic              zero,
    input  logic [2*BW-1:0]   rem,
    input  logic [2*BW-1:0]   quo,
    input  logic [4*BW-1:0]   orig,
    output logic [4*BW-1:0]   result
);
    localparam int unsigned WW = 2 * BW;
    localparam int unsigned DW = 2 * WW;

    logic [WW-1:0] q_mag;
    logic [WW-1:0] r_mag;
    logic [WW-1:0] q_s;
    logic [WW-1:0] r_s;
    logic          q_top;
    logic          q_rest_nz;
    logic          range_bad;
    logic          hold;
    logic [DW-1:0] packed_w;

    always_comb begin
        if (word) begin
            q_mag     = quo;
            r_mag     = rem;
            q_top     = quo[WW-1];
            q_rest_nz = |quo[WW-2:0];
        end else begin
            q_mag     = {{BW{1'b0}}, quo[BW-1:0]};
            r_mag     = {{BW{1'b0}}, rem[BW-1:0]};
            q_top     = quo[BW-1];
            q_rest_nz = |quo[BW-2:0];
        end

        q_s = q_neg ? (~q_mag + 1'b1) : q_mag;
        r_s = r_neg ? (~r_mag + 1'b1) : r_mag;

        // Signed field fits one more negative value than positive
        range_bad = sgn & (q_neg ? (q_top & q_rest_nz) : q_top);
        hold      = ovf_pre | zero | range_bad;

        if (word)
            packed_w = {r_s, q_s};
        else
            packed_w = {orig[DW-1:WW], r_s[BW-1:0], q_s[BW-1:0]};

        result = hold ? orig : packed_w;
    end

endmodule

// File: rtl/packed_divider.sv
module packed_divider
    import packed_divider_pkg::*;
#(
    parameter int unsigned BW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              word_i,
    input  logic              signed_i,
    input  logic [4*BW-1:0]   dividend_i,
    input  logic [2*BW-1:0]   divisor_i,
    output logic [4*BW-1:0]   result_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_we_o,
    output logic              done_o
);
    localparam int unsigned WW      = 2 * BW;
    localparam int unsigned DW      = 2 * WW;
    localparam int unsigned LAT_MAX = op_latency(BW, 1'b1, 1'b1);
    localparam int unsigned CW      = $clog2(LAT_MAX + 1);

    div_state_e    state;
    logic [CW-1:0] cnt;
    div_cfg_t      cfg_r;
    div_info_t     info_r;
    logic [DW-1:0] orig_r;
    logic [WW-1:0] dvs_r;

    logic [DW-1:0] result_r;
    logic          fn_r;
    logic          fz_r;
    logic          done_r;

    logic          accept;
    logic          step;
    logic [CW-1:0] last_cnt;
    logic [CW-1:0] n_steps;

    logic [WW-1:0] p_rem_init;
    logic [WW-1:0] p_q_init;
    logic [WW-1:0] p_dvs_mag;
    div_info_t     p_info;
    logic [WW-1:0] c_rem;
    logic [WW-1:0] c_quo;
    logic [DW-1:0] packed_res;

    div_operand_prep #(.BW(BW)) u_prep (
        .word     (word_i),
        .sgn      (signed_i),
        .dvd      (dividend_i),
        .dvs      (divisor_i),
        .rem_init (p_rem_init),
        .q_init   (p_q_init),
        .dvs_mag  (p_dvs_mag),
        .info     (p_info)
    );

    always_comb begin
        accept   = (state == ST_IDLE) && start_i;
        last_cnt = CW'(op_latency(BW, cfg_r.word, cfg_r.sgn) - 1);
        n_steps  = CW'(step_count(BW, cfg_r.word));
        step     = (state == ST_RUN) && (cnt < n_steps);
    end

    div_step_core #(.WW(WW)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .step     (step),
        .rem_init (p_rem_init),
        .q_init   (p_q_init),
        .dvs      (accept ? p_dvs_mag : dvs_r),
        .rem_o    (c_rem),
        .q_o      (c_quo)
    );

    div_result_pack #(.BW(BW)) u_pack (
        .word    (cfg_r.word),
        .sgn     (cfg_r.sgn),
        .q_neg   (info_r.q_neg),
        .r_neg   (info_r.r_neg),
        .ovf_pre (info_r.ovf),
        .zero    (info_r.zero),
        .rem     (c_rem),
        .quo     (c_quo),
        .orig    (orig_r),
        .result  (packed_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cfg_r    <= '0;
            info_r   <= '0;
            orig_r   <= '0;
            dvs_r    <= '0;
            result_r <= '0;
            fn_r     <= 1'b0;
            fz_r     <= 1'b0;
            done_r   <= 1'b0;
        end else begin
            done_r <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state      <= ST_RUN;
                        cnt        <= '0;
                        cfg_r.word <= word_i;
                        cfg_r.sgn  <= signed_i;
                        info_r     <= p_info;
                        orig_r     <= dividend_i;
                        dvs_r      <= p_dvs_mag;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == last_cnt) begin
                        state    <= ST_IDLE;
                        done_r   <= 1'b1;
                        result_r <= packed_res;
                        fn_r     <= info_r.n;
                        fz_r     <= info_r.zero;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign result_o  = result_r;
    assign flag_n_o  = fn_r;
    assign flag_z_o  = fz_r;
    assign flag_we_o = done_r;
    assign done_o    = done_r;

    // Independent latency counter used only by the checks below
    logic [CW-1:0] lat_ctr;
    always_ff @(posedge clk) begin
        if (rst)
            lat_ctr <= '0;
        else if (accept)
            lat_ctr <= '0;
        else if (state == ST_RUN)
            lat_ctr <= lat_ctr + 1'b1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R4
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lat_ctr == CW'(op_latency(BW, cfg_r.word, cfg_r.sgn))));  // R4
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RUN) && start_i) |=> ($stable(orig_r) && $stable(cfg_r)));  // R9
    AST_ZERO_DIVISOR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done_o && flag_z_o) |-> (result_o == orig_r));  // R6
    AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(result_o) && $stable(flag_n_o) && $stable(flag_z_o)));  // R11

endmodule

// File: tb/packed_divider_tb.sv
module packed_divider_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        word_i;
    logic        signed_i;
    logic [31:0] dividend_i;
    logic [15:0] divisor_i;
    logic [31:0] result_o;
    logic        flag_n_o;
    logic        flag_z_o;
    logic        flag_we_o;
    logic        done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    packed_divider u_dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .word_i     (word_i),
        .signed_i   (signed_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .result_o   (result_o),
        .flag_n_o   (flag_n_o),
        .flag_z_o   (flag_z_o),
        .flag_we_o  (flag_we_o),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Arithmetic reference built directly from R1-style packing rules
    task automatic model(input logic w, input logic s, input logic [31:0] dd, input logic [15:0] dv,
                         output logic [31:0] res, output logic n, output logic z, output logic hold);
        longint a, b, q, r, hi, lo;
        int unsigned nb;
        nb = w ? 16 : 8;
        if (s) begin
            a = w ? longint'($signed(dd)) : longint'($signed(dd[15:0]));
            b = w ? longint'($signed(dv)) : longint'($signed(dv[7:0]));
            n = w ? (dd[31] ^ dv[15]) : (dd[15] ^ dv[7]);
        end else begin
            a = w ? longint'(dd) : longint'(dd[15:0]);
            b = w ? longint'(dv) : longint'(dv[7:0]);
            n = w ? dv[15] : dv[7];
        end
        z    = (b == 0);
        hold = z;
        q    = 0;
        r    = 0;
        if (!z) begin
            q  = a / b;
            r  = a % b;
            hi = s ? ((longint'(1) << (nb - 1)) - 1) : ((longint'(1) << nb) - 1);
            lo = s ? -(longint'(1) << (nb - 1)) : 0;
            if (q > hi || q < lo) hold = 1'b1;
        end
        if (hold)
            res = dd;
        else if (w)
            res = {r[15:0], q[15:0]};
        else
            res = {dd[31:16], r[7:0], q[7:0]};
    endtask

    task automatic run_op(input logic w, input logic s, input logic [31:0] dd, input logic [15:0] dv);
        logic [31:0] e_res;
        logic        e_n, e_z, e_hold;
        int          j;
        int          lat;
        string       tag;
        model(w, s, dd, dv, e_res, e_n, e_z, e_hold);
        lat = (w ? 16 : 8) + 6 + (s ? 2 : 0);
        @(negedge clk);
        start_i = 1'b1; word_i = w; signed_i = s; dividend_i = dd; divisor_i = dv;
        @(negedge clk);
        start_i = 1'b0;
        j = 0;
        while (!done_o && j < 80) begin
            @(negedge clk);
            j++;
        end
        chk(j == lat, "R4 latency", 64'(j), 64'(lat));
        if (e_z)         tag = "R6 zero-divisor result";
        else if (e_hold) tag = "R8 overflow result";
        else if (s)      tag = "R3 signed result";
        else if (w)      tag = "R2 wide result";
        else             tag = "R1 narrow result";
        chk(result_o === e_res, tag, 64'(result_o), 64'(e_res));
        chk(flag_n_o === e_n, "R7 N flag", 64'(flag_n_o), 64'(e_n));
        chk(flag_z_o === e_z, "R6 Z flag", 64'(flag_z_o), 64'(e_z));
        chk(flag_we_o === 1'b1, "R5 strobe with done", 64'(flag_we_o), 64'd1);
        @(negedge clk);
        chk(done_o === 1'b0 && flag_we_o === 1'b0, "R4 R5 single-cycle pulse",
            64'({done_o, flag_we_o}), 64'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R4 watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [31:0] x;
        logic [31:0] keep_res;
        logic        keep_n, keep_z;
        logic [31:0] e_res;
        logic        e_n, e_z, e_hold;

        rst = 1'b1; start_i = 1'b0; word_i = 1'b0; signed_i = 1'b0;
        dividend_i = '0; divisor_i = '0;
        repeat (4) @(negedge clk);
        // R10: reset values
        chk(result_o === 32'd0, "R10 result in reset", 64'(result_o), 64'd0);
        chk({done_o, flag_we_o, flag_n_o, flag_z_o} === 4'd0, "R10 strobes/flags in reset",
            64'({done_o, flag_we_o, flag_n_o, flag_z_o}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(result_o === 32'd0 && done_o === 1'b0, "R10 after reset",
            64'({done_o, result_o}), 64'd0);

        // Boundary pairs (R3, R8, R6)
        run_op(1'b0, 1'b1, 32'h1234_4000, 16'h0080);   // -128 fits (R3)
        run_op(1'b0, 1'b1, 32'h0000_4000, 16'h0040);   // +256 overflows (R8)
        run_op(1'b0, 1'b1, 32'h0000_3F80, 16'h007F);   // +128 overflows (R8)
        run_op(1'b0, 1'b1, 32'h0000_8000, 16'h00FF);   // -32768 / -1 (R8)
        run_op(1'b0, 1'b1, 32'h0000_FF85, 16'h0007);   // -123 / 7 (R3)
        run_op(1'b0, 1'b0, 32'hDEAD_0000, 16'h0000);   // zero divisor (R6)
        run_op(1'b1, 1'b1, 32'h4000_0000, 16'h8000);   // -32768 fits (R3)
        run_op(1'b1, 1'b1, 32'h3FFF_8000, 16'h7FFF);   // +32768 overflows (R8)
        run_op(1'b1, 1'b1, 32'h8000_0000, 16'hFFFF);   // (R8)
        run_op(1'b1, 1'b1, 32'hFFFF_FF85, 16'hFFF9);   // -123 / -7 (R3)
        run_op(1'b1, 1'b0, 32'h0001_0000, 16'h0001);   // 65536 overflows (R8)
        run_op(1'b1, 1'b0, 32'hFFFE_0001, 16'hFFFF);   // max fitting quotient (R2)
        run_op(1'b1, 1'b0, 32'h1234_5678, 16'h0000);   // zero divisor (R6)

        // Narrow sweep: every divisor, mixed dividends, both signednesses (R1, R3, R7)
        for (int s = 0; s < 2; s++) begin
            for (int dv = 0; dv < 256; dv++) begin
                for (int i = 0; i < 8; i++) begin
                    logic [15:0] d16;
                    logic [15:0] up;
                    up = 16'hA5C3 ^ 16'(i * 16'h0111 + dv);
                    case (i)
                        0: d16 = 16'h0000;
                        1: d16 = 16'hFFFF;
                        2: d16 = 16'h8000;
                        3: d16 = 16'(dv * ((dv * 7 + 1) & 8'h7F));
                        4: d16 = 16'(dv * ((dv + 3) & 8'hFF) + (dv > 1 ? 1 : 0));
                        default: d16 = 16'(dv * 40503 + i * 9973) ^ 16'(i << 9);
                    endcase
                    run_op(1'b0, s[0], {up, d16}, {8'h5A, 8'(dv)});
                end
            end
        end

        // Wide pseudo-random sweep (R2, R3, R7, R8)
        x = 32'h1F2E_3D4C;
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 300; k++) begin
                logic [15:0] dv16;
                logic [15:0] qq;
                logic [31:0] dd32;
                x ^= x << 13; x ^= x >> 17; x ^= x << 5;
                dv16 = (k % 4 == 0) ? {12'h000, x[3:0]} : x[15:0];
                x ^= x << 13; x ^= x >> 17; x ^= x << 5;
                qq = x[15:0];
                if (k % 2 == 0)
                    dd32 = 32'(dv16) * 32'(qq) + (dv16 == 0 ? 32'd0 : 32'(x[31:16]) % 32'(dv16));
                else
                    dd32 = x;
                run_op(1'b1, s[0], dd32, dv16);
            end
        end

        // R11: outputs hold between completions
        run_op(1'b0, 1'b0, 32'h0000_0C8F, 16'h000D);
        keep_res = result_o; keep_n = flag_n_o; keep_z = flag_z_o;
        dividend_i = 32'hFFFF_FFFF; divisor_i = 16'h0003;
        repeat (6) @(negedge clk);
        chk(result_o === keep_res && flag_n_o === keep_n && flag_z_o === keep_z,
            "R11 hold between completions", 64'(result_o), 64'(keep_res));

        // R9: second request during a run is ignored
        model(1'b1, 1'b0, 32'h0009_8765, 16'h0123, e_res, e_n, e_z, e_hold);
        @(negedge clk);
        start_i = 1'b1; word_i = 1'b1; signed_i = 1'b0;
        dividend_i = 32'h0009_8765; divisor_i = 16'h0123;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1; word_i = 1'b0; signed_i = 1'b1;
        dividend_i = 32'h0000_7777; divisor_i = 16'h0000;
        @(negedge clk);
        start_i = 1'b0;
        begin
            int j;
            j = 4;
            while (!done_o && j < 80) begin
                @(negedge clk);
                j++;
            end
            chk(j == 22, "R9 latency of running op", 64'(j), 64'd22);
        end
        chk(result_o === e_res, "R9 running op result intact", 64'(result_o), 64'(e_res));
        begin
            int extra;
            extra = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            chk(extra == 0, "R9 no completion for ignored start", 64'(extra), 64'd0);
        end

        finish_run();
    end

endmodule